// File: doc/BRIEF.md
# Staged Control Word Carrier for a Five-Stage Pipeline

This block turns the operation field of the instruction sitting in the decode stage of a five-stage load/store pipeline into a control word, then carries that word forward with the instruction. The word is split by consumer. The execute group selects the destination register field, the ALU operation class and the ALU second operand. The memory group holds the branch, read and write strobes. The writeback group holds the register write enable and the choice between memory data and ALU result.

The full word is loaded into the decode/execute register. Only the memory and writeback groups move on into the execute/memory register, and only the writeback group reaches the memory/writeback register. Each stage therefore sees its own group at its boundary and drops it once used.

A bubble request loads a zero control word into the decode/execute register. This stalls the pipeline with an instruction that changes nothing. A flush request squashes the two youngest instructions in flight by zeroing what enters both the decode/execute and the execute/memory registers. The datapath fields travel in separate registers owned by the surrounding pipeline.

Top module: `stage_ctrl_pipe`

## Requirements
- R1: The decoded word `id_ctrl` is packed as [8]=reg_wr, [7]=mem_to_reg, [6]=branch, [5]=mem_rd, [4]=mem_wr, [3]=dst_sel, [2:1]=alu_op, [0]=alu_imm. The operation field is instruction bits [31:26]. A nonzero instruction with operation 0x00 (register-register) decodes to 9'b10_000_1100.
- R2: Operation 0x23 (load) decodes to 9'b11_010_0001.
- R3: Operation 0x2B (store) decodes to 9'b00_001_0001, so it never writes a register.
- R4: Operation 0x04 (branch on equal) decodes to 9'b00_100_0010.
- R5: An all-zero instruction word (no-op) and any other operation value decode to all zeros.
- R6: With no bubble, flush or reset, `x_ex_ctrl` equals `id_ctrl[3:0]` one cycle later. `m_mem_ctrl` equals `id_ctrl[6:4]` two cycles later, and `w_wb_ctrl` equals `id_ctrl[8:7]` three cycles later.
- R7: When `bubble_req` is high at a clock edge, the decode/execute register loads zero while the older registers still advance.
- R8: When `flush_req` is high at a clock edge, both the decode/execute and the execute/memory registers load zero while the memory/writeback register still advances. A flush together with a bubble acts as a flush.
- R9: A synchronous reset clears all three control registers, so all stage outputs read zero after the edge.
- R10: At most one bit of the memory group is set, both in decode and at the memory boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| id_instr | input | 32 | Instruction word in the decode stage |
| bubble_req | input | 1 | Insert a zero control word into decode/execute |
| flush_req | input | 1 | Squash the decode and execute instructions |
| id_ctrl | output | 9 | Decoded control word (combinational) |
| x_ex_ctrl | output | 4 | Execute group at the decode/execute boundary |
| m_mem_ctrl | output | 3 | Memory group at the execute/memory boundary |
| w_wb_ctrl | output | 2 | Writeback group at the memory/writeback boundary |

## Verification
The two functions that can land on the same edge are the bubble path and the flush path. Both want to write the decode/execute register, and a flush also kills the instruction one stage further on. The bench provokes this with directed edges where both requests are high behind a full pipeline of loads and register-register operations. It also raises both requests at random on many edges. A reference pipeline in the bench, which lets the flush win, judges every stage output on the following cycles.

// File: rtl/stage_ctrl_pkg.sv
package stage_ctrl_pkg;
  localparam int OP_W  = 6;
  localparam int EX_W  = 4;
  localparam int MEM_W = 3;
  localparam int WB_W  = 2;
  localparam int WORD_W   = WB_W + MEM_W + EX_W;
  localparam int CARRY_W  = WB_W + MEM_W;

  localparam logic [OP_W-1:0] OP_REG   = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  typedef struct packed {
    logic reg_wr;
    logic mem_to_reg;
  } wb_grp_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_grp_t;

  typedef struct packed {
    logic       dst_sel;
    logic [1:0] alu_op;
    logic       alu_imm;
  } ex_grp_t;

  typedef struct packed {
    wb_grp_t  wb;
    mem_grp_t mem;
    ex_grp_t  ex;
  } ctrl_word_t;

  typedef struct packed {
    wb_grp_t  wb;
    mem_grp_t mem;
  } ctrl_carry_t;
endpackage

// File: rtl/stage_ctrl_decoder.sv
module stage_ctrl_decoder
  import stage_ctrl_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output ctrl_word_t         word
);
  localparam int OP_LSB = INSTR_W - OP_W;

  logic [OP_W-1:0] op;
  logic            is_nop;

  assign op     = instr[INSTR_W-1:OP_LSB];
  assign is_nop = ~|instr;

  always_comb begin
    word = '0;
    if (!is_nop) begin
      unique case (op)
        OP_REG: begin
          word.wb.reg_wr  = 1'b1;
          word.ex.dst_sel = 1'b1;
          word.ex.alu_op  = 2'b10;
        end
        OP_LOAD: begin
          word.wb.reg_wr     = 1'b1;
          word.wb.mem_to_reg = 1'b1;
          word.mem.mem_rd    = 1'b1;
          word.ex.alu_imm    = 1'b1;
        end
        OP_STORE: begin
          word.mem.mem_wr = 1'b1;
          word.ex.alu_imm = 1'b1;
        end
        OP_BEQ: begin
          word.mem.branch = 1'b1;
          word.ex.alu_op  = 2'b01;
        end
        default: word = '0;
      endcase
    end
  end
endmodule

// File: rtl/stage_ctrl_reg.sv
module stage_ctrl_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         kill,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || kill) q <= '0;
    else             q <= d;
  end
endmodule

// File: rtl/stage_ctrl_pipe.sv
module stage_ctrl_pipe
  import stage_ctrl_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] id_instr,
  input  logic               bubble_req,
  input  logic               flush_req,
  output logic [WORD_W-1:0]  id_ctrl,
  output logic [EX_W-1:0]    x_ex_ctrl,
  output logic [MEM_W-1:0]   m_mem_ctrl,
  output logic [WB_W-1:0]    w_wb_ctrl
);
  ctrl_word_t  dec_word;
  ctrl_word_t  idex_q;
  ctrl_carry_t exmem_q;
  wb_grp_t     memwb_q;
  ctrl_carry_t exmem_d;
  logic        idex_kill;

  stage_ctrl_decoder #(.INSTR_W(INSTR_W)) u_dec (
    .instr (id_instr),
    .word  (dec_word)
  );

  assign idex_kill = bubble_req | flush_req;
  assign exmem_d   = '{wb: idex_q.wb, mem: idex_q.mem};

  stage_ctrl_reg #(.W(WORD_W)) u_idex (
    .clk  (clk),
    .rst  (rst),
    .kill (idex_kill),
    .d    (dec_word),
    .q    (idex_q)
  );

  stage_ctrl_reg #(.W(CARRY_W)) u_exmem (
    .clk  (clk),
    .rst  (rst),
    .kill (flush_req),
    .d    (exmem_d),
    .q    (exmem_q)
  );

  stage_ctrl_reg #(.W(WB_W)) u_memwb (
    .clk  (clk),
    .rst  (rst),
    .kill (1'b0),
    .d    (exmem_q.wb),
    .q    (memwb_q)
  );

  assign id_ctrl    = dec_word;
  assign x_ex_ctrl  = idex_q.ex;
  assign m_mem_ctrl = exmem_q.mem;
  assign w_wb_ctrl  = memwb_q;
endmodule

// File: rtl/stage_ctrl_chk.sv
module stage_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       bubble_req,
  input logic       flush_req,
  input logic [8:0] id_ctrl,
  input logic [3:0] x_ex_ctrl,
  input logic [2:0] m_mem_ctrl,
  input logic [1:0] w_wb_ctrl,
  input logic [8:0] idex_q,
  input logic [4:0] exmem_q
);
  p_store_no_wr_r3: assert property (@(posedge clk) disable iff (rst)
    id_ctrl[4] |-> !id_ctrl[8]);

  p_ex_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (!bubble_req && !flush_req) |=> x_ex_ctrl == $past(id_ctrl[3:0]));

  p_mem_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !flush_req |=> m_mem_ctrl == $past(idex_q[6:4]));

  p_wb_follow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> w_wb_ctrl == $past(exmem_q[4:3]));

  p_bubble_zero_r7: assert property (@(posedge clk) disable iff (rst)
    bubble_req |=> idex_q == 9'd0);

  p_flush_zero_r8: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> (idex_q == 9'd0 && exmem_q == 5'd0));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (idex_q == 9'd0 && exmem_q == 5'd0 && w_wb_ctrl == 2'd0));

  p_mem_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_mem_ctrl) && $onehot0(id_ctrl[6:4]));
endmodule

bind stage_ctrl_pipe stage_ctrl_chk u_chk (.*);

// File: tb/tb_stage_ctrl_pipe.sv
`timescale 1ns/1ps
module tb_stage_ctrl_pipe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] id_instr = 32'd0;
  logic        bubble_req = 1'b0;
  logic        flush_req = 1'b0;
  logic [8:0]  id_ctrl;
  logic [3:0]  x_ex_ctrl;
  logic [2:0]  m_mem_ctrl;
  logic [1:0]  w_wb_ctrl;

  int checks = 0;
  int errors = 0;
  logic [8:0] e_idex = '0;
  logic [4:0] e_exmem = '0;
  logic [1:0] e_wb = '0;

  always #2 clk = ~clk;

  stage_ctrl_pipe dut (
    .clk        (clk),
    .rst        (rst),
    .id_instr   (id_instr),
    .bubble_req (bubble_req),
    .flush_req  (flush_req),
    .id_ctrl    (id_ctrl),
    .x_ex_ctrl  (x_ex_ctrl),
    .m_mem_ctrl (m_mem_ctrl),
    .w_wb_ctrl  (w_wb_ctrl)
  );

  function automatic logic [8:0] ref_dec(input logic [31:0] w);
    if (w == 32'd0) return 9'd0;
    case (w[31:26])
      6'h00:   return 9'b10_000_1100;
      6'h23:   return 9'b11_010_0001;
      6'h2B:   return 9'b00_001_0001;
      6'h04:   return 9'b00_100_0010;
      default: return 9'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, "x_ex_ctrl", {5'd0, x_ex_ctrl}, {5'd0, e_idex[3:0]});
    chk(req, "m_mem_ctrl", {6'd0, m_mem_ctrl}, {6'd0, e_exmem[2:0]});
    chk(req, "w_wb_ctrl", {7'd0, w_wb_ctrl}, {7'd0, e_wb});
  endtask

  // one cycle: drive at negedge, check decode, clock, advance the reference
  task automatic step(input logic r, input logic [31:0] ins,
                      input logic bub, input logic fl, input string req);
    rst = r; id_instr = ins; bubble_req = bub; flush_req = fl;
    #1;
    chk(req, "id_ctrl", id_ctrl, ref_dec(ins));
    @(posedge clk);
    if (r) begin
      e_idex = '0; e_exmem = '0; e_wb = '0;
    end else begin
      e_wb    = e_exmem[4:3];
      e_exmem = fl ? 5'd0 : e_idex[8:4];
      e_idex  = (fl || bub) ? 9'd0 : ref_dec(ins);
    end
    @(negedge clk);
    chk_outs(req);
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op);
    return {op, 26'h0A5_1234};
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    step(1'b1, mk(6'h23), 1'b0, 1'b0, "R9");
    step(1'b1, mk(6'h00), 1'b0, 1'b0, "R9");
    // decode of every class, then drain to watch the groups travel (R6)
    step(1'b0, mk(6'h00), 1'b0, 1'b0, "R1");
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R2");
    step(1'b0, mk(6'h2B), 1'b0, 1'b0, "R3");
    step(1'b0, mk(6'h04), 1'b0, 1'b0, "R4");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R5");
    step(1'b0, mk(6'h3F), 1'b0, 1'b0, "R5");
    step(1'b0, 32'h0000_0020, 1'b0, 1'b0, "R1");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R6");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R6");
    // bubble behind loads: decode/execute zero, older stages move (R7)
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R7");
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R7");
    step(1'b0, mk(6'h00), 1'b1, 1'b0, "R7");
    step(1'b0, mk(6'h00), 1'b0, 1'b0, "R7");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R7");
    // flush with full pipeline, then flush and bubble together (R8)
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R8");
    step(1'b0, mk(6'h00), 1'b0, 1'b0, "R8");
    step(1'b0, mk(6'h2B), 1'b0, 1'b1, "R8");
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R8");
    step(1'b0, mk(6'h00), 1'b0, 1'b0, "R8");
    step(1'b0, mk(6'h04), 1'b1, 1'b1, "R8");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R8");
    step(1'b0, 32'd0, 1'b0, 1'b0, "R8");
    // reset in the middle of traffic (R9)
    step(1'b0, mk(6'h23), 1'b0, 1'b0, "R9");
    step(1'b0, mk(6'h00), 1'b0, 1'b0, "R9");
    step(1'b1, mk(6'h23), 1'b0, 1'b0, "R9");
    // random traffic; memory group exclusivity judged too (R10)
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] w;
      logic [5:0]  op;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    op = 6'h00;
        2, 3:    op = 6'h23;
        4:       op = 6'h2B;
        5:       op = 6'h04;
        default: op = 6'($urandom);
      endcase
      w = {op, 26'($urandom)};
      if ($urandom_range(0, 15) == 0) w = 32'd0;
      step(($urandom_range(0, 99) == 0), w,
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 9) == 0), "R6");
      checks++;
      if ($countones(m_mem_ctrl) > 1) begin
        errors++;
        $display("FAIL R10 m_mem_ctrl: got %b expected at most one bit", m_mem_ctrl);
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule